// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block watches an already demodulated infrared line and turns it into a stream of timing words. The line rests high. A symbol begins when the line falls, and it ends when the line falls again, or when the high phase lasts too long. Each symbol gives one 32-bit word: the low-phase length in the lower half and the high-phase length in the upper half. Both lengths are counted in 10 µs units. The block derives those units from the system clock through a programmable prescaler. Words go into a receive FIFO that software drains through a small synchronous register port. Three interrupt causes are provided: symbols received, line timeout and FIFO overflow.

A high phase that reaches the programmed maximum width ends the stream. The word is closed with the maximum value in its high half, and the receiver waits for the next falling edge. An overflow does not flush anything: words already stored stay readable in order. The input passes through a two-flop synchroniser and a three-sample majority filter before its edges are detected.

Register word addresses on `reg_addr`:

| Address | Register |
|---|---|
| 0 | enable, bit 0 |
| 1 | config |
| 2 | busy |
| 3 | count |
| 4 | data, popped on read |
| 5 | mask, bits 2:0 |
| 6 | status |
| 7 | clear |
| 8 | start |

Top module: `ir_pulse_capture`

## Requirements
- R1: After reset:
  - config (address 1) reads 0x3E800080.
  - count (address 3) reads 0.
  - status (address 6) reads 0.
  - busy (address 2) reads 0.
  - `irq` is low.
- R2: A write of bit 0 = 1 to enable (address 0) while disabled makes busy (address 2, bit 0) read 1 for 16 cycles. Busy then returns to 0.
- R3: Symbols are captured only after a write of any value to start (address 8) while enabled and not busy. Writing enable = 0 does three things:
  - it disarms capture;
  - it empties the FIFO;
  - it clears all flags.
- R4: A symbol word holds the low count in bits 15:0 and the high count in bits 31:16. A phase lasting d clock cycles counts (d-1)/P units, using integer division, where P = (freq + 1) * 10.
- R5: If the high phase reaches the maximum width (config bits 31:16), the symbol is closed with the high half equal to the maximum width. The timeout flag (status bit 25) is set, and no further word is produced until the next falling edge.
- R6: Count (address 3) returns the number of stored words. Each read of data (address 4) returns the oldest word and removes it. A read of an empty FIFO returns 0 and changes nothing.
- R7: The received flag (status bit 24) is set when a stored word brings the count above the level field (config bits 13:8). A level of 0 therefore means one word.
- R8: The FIFO holds 64 words. A word arriving when the FIFO is full is dropped and sets the overflow flag (status bit 26). The 64 stored words remain readable in order.
- R9: Status layout:
  - bits 26:24 hold the raw overflow, timeout and received flags;
  - bits 10:8 hold the same flags ANDed with the inverse of mask bits 2:0.
  
  `irq` is the OR of bits 10:8. The mask resets to 3'b111.
- R10: Writing 1 to clear (address 7) bits 16, 17 or 18 clears the received, timeout or overflow flag respectively. Zero bits leave their flag unchanged.
- R11: A low pulse on `ir_in` lasting one clock cycle is filtered out and produces no symbol.
- R12: All 32 config bits are written and read back unchanged:
  - 31:16 maximum width;
  - 15:14 format;
  - 13:8 level;
  - 7 raw-mode;
  - 6:0 frequency in MHz minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| ir_in | input | 1 | demodulated infrared line, idle high, asynchronous |
| reg_addr | input | 4 | register word address |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | read data, valid the cycle after `reg_rd` |
| irq | output | 1 | OR of the unmasked flags |

## Verification
- **Duration grid at the fastest prescaler.** Low and high durations are swept over a grid at prescaler 0, placing each edge half a unit past a whole count. This separates a correct count from one that is off by one or rounds the wrong way, and it shows whether the two halves of the word are swapped.
- **Second prescaler setting.** A coarser grid at prescaler 2 shows whether the frequency field scales the unit at all.
- **Long high phase.** Holding the line high past the maximum width checks saturation and the timeout flag.
- **Level boundary.** A status read between the 30th and 31st word checks the level comparison at its exact edge.
- **Overflow burst.** A burst of 67 varied symbols checks that the first 64 words survive in order.
- **Glitch and disarmed capture.** A single-cycle glitch, and pulses sent while disarmed, must both leave the count at zero.

// File: rtl/ir_cap_pkg.sv
// Shared definitions for the infrared pulse-width capture receiver:
// register word addresses, the config layout, the measurement phases
// and the interrupt flag bundle. Assumes 32-bit register data.
package ir_cap_pkg;

    localparam int SYM_W = 16;

    localparam logic [3:0] A_ENABLE = 4'd0;
    localparam logic [3:0] A_CONFIG = 4'd1;
    localparam logic [3:0] A_BUSY   = 4'd2;
    localparam logic [3:0] A_COUNT  = 4'd3;
    localparam logic [3:0] A_DATA   = 4'd4;
    localparam logic [3:0] A_MASK   = 4'd5;
    localparam logic [3:0] A_STATUS = 4'd6;
    localparam logic [3:0] A_CLEAR  = 4'd7;
    localparam logic [3:0] A_START  = 4'd8;

    localparam logic [31:0] CFG_RESET = 32'h3E80_0080;

    typedef struct packed {
        logic [15:0] max_width;
        logic [1:0]  fmt;
        logic [5:0]  level;
        logic        raw;
        logic [6:0]  freq;
    } cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/ir_in_filter.sv
// Input conditioning: two-flop synchroniser, three-sample majority vote,
// then edge detection on the filtered level. Both edges see the same
// latency, so measured durations equal input durations.
// Assumes the line idles high; all stages reset to 1.
module ir_in_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_in,
    output logic fall,
    output logic rise
);
    logic sync1, sync2, hist0, hist1, filt_q, filt_d, vote;

    // Majority of the newest three synchronised samples.
    always_comb vote = (sync2 & hist0) | (sync2 & hist1) | (hist0 & hist1);

    // Synchroniser, sample history and filtered level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1  <= 1'b1;
            sync2  <= 1'b1;
            hist0  <= 1'b1;
            hist1  <= 1'b1;
            filt_q <= 1'b1;
            filt_d <= 1'b1;
        end else begin
            sync1  <= ir_in;
            sync2  <= sync1;
            hist0  <= sync2;
            hist1  <= hist0;
            filt_q <= vote;
            filt_d <= filt_q;
        end
    end

    // Single-cycle edge strobes on the filtered level.
    always_comb begin
        fall = filt_d & ~filt_q;
        rise = ~filt_d & filt_q;
    end
endmodule

// File: rtl/ir_tick_gen.sv
// Measurement tick: divides the clock by (freq+1) for a 1 MHz strobe and
// by TICK_DIV again for the unit tick. A restart zeroes both stages so
// the first tick lands exactly one unit after the restart cycle.
module ir_tick_gen #(
    parameter int TICK_DIV = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [6:0] freq,
    output logic       tick
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [6:0]    pre_q;
    logic [DW-1:0] dec_q;
    logic          us_strobe;

    // Strobes from the two divider stages.
    always_comb begin
        us_strobe = (pre_q == freq);
        tick      = us_strobe && (dec_q == DW'(TICK_DIV - 1));
    end

    // Prescaler and decade counter, both cleared by restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
            dec_q <= '0;
        end else if (us_strobe) begin
            pre_q <= '0;
            dec_q <= (dec_q == DW'(TICK_DIV - 1)) ? '0 : dec_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/ir_symbol_meas.sv
// Symbol measurement: counts ticks of the low phase, then of the high
// phase. Emits one word on the next falling edge, or when the high count
// reaches max_width (timeout, high half saturated). A tick in an edge
// cycle is not counted. Assumes edges alternate.
module ir_symbol_meas
    import ir_cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               fall,
    input  logic               rise,
    input  logic               tick,
    input  logic [SYM_W-1:0]   max_width,
    output logic               push,
    output logic [2*SYM_W-1:0] push_word,
    output logic               tmo_evt
);
    phase_e           phase_q;
    logic [SYM_W-1:0] low_q, high_q;
    logic             at_limit;

    // Would this tick carry the high count to the limit?
    always_comb at_limit = ({1'b0, high_q} + 1'b1) >= {1'b0, max_width};

    // Symbol completion decode.
    always_comb begin
        push      = 1'b0;
        tmo_evt   = 1'b0;
        push_word = {high_q, low_q};
        if (active && phase_q == PH_HIGH) begin
            if (fall) begin
                push = 1'b1;
            end else if (tick && at_limit) begin
                push      = 1'b1;
                tmo_evt   = 1'b1;
                push_word = {max_width, low_q};
            end
        end
    end

    // Phase sequencing and duration counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            phase_q <= PH_IDLE;
            low_q   <= '0;
            high_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (fall) begin
                    phase_q <= PH_LOW;
                    low_q   <= '0;
                end
                PH_LOW: if (rise) begin
                    phase_q <= PH_HIGH;
                    high_q  <= '0;
                end else if (tick && low_q != '1) begin
                    low_q <= low_q + 1'b1;
                end
                PH_HIGH: if (fall) begin
                    phase_q <= PH_LOW;
                    low_q   <= '0;
                end else if (tmo_evt) begin
                    phase_q <= PH_IDLE;
                end else if (tick) begin
                    high_q <= high_q + 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ir_sym_fifo.sv
// Receive FIFO in flops. A push into a full FIFO is refused (accept low)
// and the stored words are untouched. head shows the oldest word.
// flush empties it. Pointers wrap explicitly, so DEPTH need not be a
// power of two.
module ir_sym_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  logic [W-1:0]    wdata,
    input  logic            pop,
    output logic [W-1:0]    head,
    output logic [CNTW-1:0] count,
    output logic            full,
    output logic            accept
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic          pop_ok;

    // Occupancy decode.
    always_comb begin
        full   = (count == CNTW'(DEPTH));
        accept = push && !full;
        pop_ok = pop && (count != '0);
        head   = mem[rd_q];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_q] <= wdata;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (accept) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop_ok) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            count <= count + CNTW'(accept) - CNTW'(pop_ok);
        end
    end
endmodule

// File: rtl/ir_pulse_capture.sv
// Top of the infrared pulse-width capture receiver. Holds the register
// port, enable/busy/start control, config, mask and the three sticky
// flags, and connects filter, tick generator, measurement and FIFO.
// Reads return data the cycle after reg_rd; a data read pops.
module ir_pulse_capture
    import ir_cap_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int TICK_DIV    = 10,
    parameter int INIT_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_in,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int CNTW = $clog2(FIFO_DEPTH + 1);
    localparam int BW   = $clog2(INIT_CYCLES + 1);

    logic            en_q, armed_q, busy, active;
    logic [BW-1:0]   busy_q;
    cfg_t            cfg_q;
    logic [2:0]      mask_q, flags_q, masked, set_vec, clr_vec;
    logic [31:0]     rd_val;
    logic            fall, rise, tick;
    logic            sym_push, sym_tmo;
    logic [31:0]     sym_word, fifo_head;
    logic [CNTW-1:0] fifo_count;
    logic            fifo_full, fifo_accept, pop_req;
    logic [CNTW:0]   count_after;

    // Control decode.
    always_comb begin
        busy    = (busy_q != '0);
        active  = en_q && armed_q && !busy;
        pop_req = reg_rd && reg_addr == A_DATA && fifo_count != '0;
        clr_vec = (reg_wr && reg_addr == A_CLEAR) ? reg_wdata[18:16] : 3'b000;
        masked  = flags_q & ~mask_q;
        irq     = |masked;
    end

    // Occupancy after this cycle, for the level comparison.
    always_comb begin
        count_after = {1'b0, fifo_count} + (CNTW+1)'(fifo_accept) - (CNTW+1)'(pop_req);
        set_vec[2]  = sym_push && fifo_full;
        set_vec[1]  = sym_tmo;
        set_vec[0]  = fifo_accept && (int'(count_after) > int'(cfg_q.level));
    end

    // Enable bit and initialisation busy counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            busy_q <= '0;
        end else begin
            if (reg_wr && reg_addr == A_ENABLE) en_q <= reg_wdata[0];
            if (reg_wr && reg_addr == A_ENABLE && reg_wdata[0] && !en_q)
                busy_q <= BW'(INIT_CYCLES);
            else if (busy)
                busy_q <= busy_q - 1'b1;
        end
    end

    // Start strobe arms capture until the block is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q)                        armed_q <= 1'b0;
        else if (reg_wr && reg_addr == A_START)     armed_q <= 1'b1;
    end

    // Config and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= cfg_t'(CFG_RESET);
            mask_q <= 3'b111;
        end else begin
            if (reg_wr && reg_addr == A_CONFIG) cfg_q  <= cfg_t'(reg_wdata);
            if (reg_wr && reg_addr == A_MASK)   mask_q <= reg_wdata[2:0];
        end
    end

    // Sticky flags: a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_q) flags_q <= 3'b000;
        else                 flags_q <= (flags_q & ~clr_vec) | set_vec;
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            A_ENABLE: rd_val = {31'd0, en_q};
            A_CONFIG: rd_val = cfg_q;
            A_BUSY:   rd_val = {31'd0, busy};
            A_COUNT:  rd_val = 32'(fifo_count);
            A_DATA:   rd_val = (fifo_count != '0) ? fifo_head : 32'd0;
            A_MASK:   rd_val = {29'd0, mask_q};
            A_STATUS: rd_val = {5'd0, flags_q, 13'd0, masked, 8'd0};
            default:  rd_val = 32'd0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= 32'd0;
        else if (reg_rd) reg_rdata <= rd_val;
    end

    ir_in_filter i_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .ir_in (ir_in),
        .fall  (fall),
        .rise  (rise)
    );

    ir_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fall || rise || !active),
        .freq    (cfg_q.freq),
        .tick    (tick)
    );

    ir_symbol_meas i_meas (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .fall      (fall),
        .rise      (rise),
        .tick      (tick),
        .max_width (cfg_q.max_width),
        .push      (sym_push),
        .push_word (sym_word),
        .tmo_evt   (sym_tmo)
    );

    ir_sym_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) i_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (!en_q),
        .push   (sym_push),
        .wdata  (sym_word),
        .pop    (pop_req),
        .head   (fifo_head),
        .count  (fifo_count),
        .full   (fifo_full),
        .accept (fifo_accept)
    );
endmodule

// File: rtl/ir_cap_checker.sv
// Temporal checks on the capture receiver, attached by bind. Observes the
// register port and the signals passed between the control, measurement
// and FIFO pieces.
module ir_cap_checker #(
    parameter int DEPTH = 64,
    parameter int CNTW  = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [3:0]      reg_addr,
    input logic [31:0]     reg_wdata,
    input logic            en_q,
    input logic            busy,
    input logic            active,
    input logic            push,
    input logic [31:0]     push_word,
    input logic            tmo_evt,
    input logic [15:0]     max_width,
    input logic [CNTW-1:0] fifo_count,
    input logic            fifo_full,
    input logic            pop_ok,
    input logic            accept,
    input logic [2:0]      flags,
    input logic            rcv_set
);
    AST_BUSY_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd0 && reg_wdata[0] && !en_q) |=> busy); // R2

    AST_NO_CAPTURE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !push); // R3

    AST_NORMAL_HIGH_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !tmo_evt) |-> (push_word[31:16] < max_width)); // R4

    AST_TIMEOUT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |-> (push && push_word[31:16] == max_width)); // R5

    AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !accept && en_q) |=> (fifo_count == $past(fifo_count) - 1'b1)); // R6

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_count) <= DEPTH); // R8

    AST_OVERFLOW_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_full && en_q) |=> flags[2]); // R8

    AST_CLEAR_RECEIVED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd7 && reg_wdata[16] && !rcv_set) |=> !flags[0]); // R10
endmodule

bind ir_pulse_capture ir_cap_checker #(.DEPTH(FIFO_DEPTH), .CNTW(CNTW)) i_ir_cap_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .en_q       (en_q),
    .busy       (busy),
    .active     (active),
    .push       (sym_push),
    .push_word  (sym_word),
    .tmo_evt    (sym_tmo),
    .max_width  (cfg_q.max_width),
    .fifo_count (fifo_count),
    .fifo_full  (fifo_full),
    .pop_ok     (pop_req),
    .accept     (fifo_accept),
    .flags      (flags_q),
    .rcv_set    (set_vec[0])
);

// File: tb/test_ir_pulse_capture.sv
// Self-checking bench: sweeps symbol durations at two prescaler settings,
// then covers timeout, level, overflow, glitch and disable behaviour.
// Expected counts come from (d-1)/P.
module test_ir_pulse_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] exp_q[$];

    always #2 clk = ~clk;

    ir_pulse_capture i_ir_pulse_capture (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        reg_read(a, v);
        check(v === e, req, v, e);
    endtask

    task automatic drive_sym(input int lo, input int hi);
        ir_in = 1'b0;
        repeat (lo) @(negedge clk);
        ir_in = 1'b1;
        repeat (hi) @(negedge clk);
    endtask

    function automatic logic [31:0] word(input int hi_units, input int lo_units);
        return {16'(hi_units), 16'(lo_units)};
    endfunction

    task automatic drain_and_compare(input string req);
        logic [31:0] v;
        expect_reg(4'd3, 32'(exp_q.size()), req);
        while (exp_q.size() > 0) begin
            logic [31:0] e;
            e = exp_q.pop_front();
            reg_read(4'd4, v);
            check(v === e, req, v, e);
        end
    endtask

    function automatic logic [31:0] cfg(input int mw, input int lvl, input int fr);
        return {16'(mw), 2'b00, 6'(lvl), 1'b1, 7'(fr)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_reg(4'd1, 32'h3E80_0080, "R1 config");
        expect_reg(4'd3, 32'd0, "R1 count");
        expect_reg(4'd6, 32'd0, "R1 status");
        expect_reg(4'd2, 32'd0, "R1 busy");
        check(irq === 1'b0, "R1 irq", 32'(irq), 0);

        // R12 config readback
        reg_write(4'd1, 32'hA5C3_9E81);
        expect_reg(4'd1, 32'hA5C3_9E81, "R12 readback");
        reg_write(4'd1, cfg(20, 30, 0));

        // R2 busy window
        reg_write(4'd0, 32'd1);
        expect_reg(4'd2, 32'd1, "R2 busy set");
        // R3 pulses before start are ignored
        drive_sym(25, 25);
        drive_sym(25, 300);
        expect_reg(4'd2, 32'd0, "R2 busy cleared");
        expect_reg(4'd3, 32'd0, "R3 not armed");

        reg_write(4'd8, 32'h0);

        // R4 sweep at P=10, level 30, max width 20
        for (int lk = 0; lk < 6; lk++) begin
            for (int hk = 0; hk < 5; hk++) begin
                drive_sym(lk * 10 + 5, hk * 10 + 5);
                exp_q.push_back(word(hk, lk));
            end
        end
        // R7 boundary: 30 words stored, level 30 -> not yet
        ir_in = 1'b0;
        repeat (10) @(negedge clk);
        reg_read(4'd6, v);
        check(v[24] === 1'b0, "R7 below level", v, 32'd0);
        repeat (23) @(negedge clk);
        ir_in = 1'b1;
        repeat (300) @(negedge clk);
        exp_q.push_back(word(20, 3));          // R5 saturated high
        expect_reg(4'd6, 32'h0300_0000, "R5 R7 flags raw");
        drain_and_compare("R4 R5 R6 sweep P=10");
        expect_reg(4'd4, 32'd0, "R6 empty read");
        expect_reg(4'd3, 32'd0, "R6 empty count");

        // R9 mask, R10 clear
        reg_write(4'd5, 32'd0);
        expect_reg(4'd6, 32'h0300_0300, "R9 unmasked");
        check(irq === 1'b1, "R9 irq on", 32'(irq), 1);
        reg_write(4'd7, 32'h0002_0000);
        expect_reg(4'd6, 32'h0100_0100, "R10 clear timeout");
        reg_write(4'd7, 32'h0001_0000);
        expect_reg(4'd6, 32'h0000_0000, "R10 clear received");
        check(irq === 1'b0, "R9 irq off", 32'(irq), 0);

        // R4 sweep at P=30, level 0, max width 5
        reg_write(4'd1, cfg(5, 0, 2));
        for (int lk = 0; lk < 4; lk++) begin
            for (int hk = 0; hk < 4; hk++) begin
                drive_sym(lk * 30 + 15, hk * 30 + 15);
                exp_q.push_back(word(hk, lk));
            end
        end
        drive_sym(45, 400);
        exp_q.push_back(word(5, 1));
        expect_reg(4'd6, 32'h0300_0300, "R7 level zero");
        drain_and_compare("R4 sweep P=30");
        reg_write(4'd7, 32'h0007_0000);

        // R11 one-cycle glitch
        ir_in = 1'b0;
        @(negedge clk);
        ir_in = 1'b1;
        repeat (300) @(negedge clk);
        expect_reg(4'd3, 32'd0, "R11 glitch");

        // R8 overflow, 67 words offered
        reg_write(4'd1, cfg(3, 0, 0));
        for (int i = 0; i < 66; i++) begin
            drive_sym((i % 4) * 10 + 5, 15);
            if (i < 64) exp_q.push_back(word(1, i % 4));
        end
        drive_sym(15, 100);
        reg_read(4'd6, v);
        check(v[26] === 1'b1, "R8 overflow flag", v, 32'h0400_0000);
        drain_and_compare("R8 contents kept");
        reg_write(4'd7, 32'h0004_0000);
        reg_read(4'd6, v);
        check(v[26] === 1'b0, "R10 clear overflow", v, 32'd0);

        // R3 disable flushes and disarms
        drive_sym(25, 25);
        drive_sym(15, 100);
        expect_reg(4'd3, 32'd2, "R3 captured");
        reg_write(4'd0, 32'd0);
        expect_reg(4'd3, 32'd0, "R3 flushed");
        expect_reg(4'd6, 32'd0, "R3 flags cleared");
        drive_sym(25, 100);
        expect_reg(4'd3, 32'd0, "R3 disabled");
        reg_write(4'd0, 32'd1);
        repeat (30) @(negedge clk);
        drive_sym(25, 100);
        expect_reg(4'd3, 32'd0, "R3 re-enabled not armed");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule